// File: doc/BRIEF.md
# Ring Buffer with Last-Operation Full/Empty Discrimination

This block is a single-clock producer/consumer ring buffer. The producer presents a word with a valid strobe. That word is stored at the put index, and the index moves forward. The consumer raises a request to take the word at the get index, and that index moves forward. Both indices return to slot 0 after the last slot, so the buffer can run without end. The word at the get index is always visible on the read port before the request is made, so data falls through to the reader.

The two indices alone cannot tell a full buffer from an empty one, because in both cases they are equal. The block keeps a single register for this. It records whether the most recent index change was a put or a get. Equal indices after a put mean full. Equal indices after a get mean empty. No extra index bit is needed.

If the producer writes into a full buffer, the word is dropped and a sticky overflow flag is raised. A dedicated clear input lowers that flag. If the consumer reads from an empty buffer, nothing changes.

Top module: `fifo_lastop_ring`

## Requirements
- R1: After reset, empty is 1, full is 0 and overflow is 0.
- R2: Words leave in exactly the order they were accepted. While empty is 0, get_data shows the oldest stored word.
- R3: Both indices wrap from slot DEPTH-1 to slot 0. Order is kept across any number of wraps.
- R4: full is 1 exactly when DEPTH words are held, and empty is 1 exactly when none are held. The two are never 1 together.
- R5: A put while full, with no get in the same cycle, is dropped. The stored words stay unchanged and overflow is set in the next cycle.
- R6: A get while empty, with no put in the same cycle, is ignored. empty stays 1 and the next accepted word is read out correctly.
- R7: overflow stays 1 until ovf_clear is 1 at a clock edge. If ovf_clear comes in the same cycle as a new dropped put, overflow stays 1.
- R8: A put and a get in the same cycle, when the buffer is neither empty nor full, are both performed. The fill level and the flags stay unchanged.
- R9: A put and a get in the same cycle while full are both performed. full stays 1, overflow is not set, and get_data moves to the next word.
- R10: A put and a get in the same cycle while empty perform only the put. empty falls to 0 and get_data shows the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| put_valid | input | 1 | Producer offers put_data this cycle |
| put_data | input | WIDTH | Word to store |
| get_req | input | 1 | Consumer takes the word on get_data this cycle |
| get_data | output | WIDTH | Oldest stored word (valid while empty is 0) |
| ovf_clear | input | 1 | Lowers the sticky overflow flag |
| empty | output | 1 | No words held |
| full | output | 1 | DEPTH words held |
| overflow | output | 1 | Sticky: a put was dropped while full |

## Verification
A put and a get can fall in the same cycle, and the result depends on the fill state at that moment. The bench drives the two strobes together when the buffer is empty, partly filled and full. It compares the flags and the visible word after each edge against a queue model in the bench. A dropped put can also meet ovf_clear in the same cycle. The bench provokes that collision and requires overflow to stay set.

// File: rtl/lor_pkg.sv
package lor_pkg;
    typedef enum logic {
        OP_GET = 1'b0,
        OP_PUT = 1'b1
    } lor_op_e;
endpackage

// File: rtl/lor_ptr.sv
module lor_ptr #(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [AW-1:0] idx
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] idx;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            if (st_q.idx == LAST) st_d.idx = '0;
            else                  st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx = st_q.idx;
endmodule

// File: rtl/lor_store.sv
module lor_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (we && (waddr == AW'(i))) mem_d[i] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/lor_ctrl.sv
module lor_ctrl
    import lor_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic put_valid,
    input  logic get_req,
    input  logic ovf_clear,
    input  logic idx_equal,
    output logic do_put,
    output logic do_get,
    output logic empty,
    output logic full,
    output logic overflow
);
    typedef struct packed {
        lor_op_e last;
        logic    ovf;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        is_full, is_empty, drop;

    assign is_full  = idx_equal && (st_q.last == OP_PUT);
    assign is_empty = idx_equal && (st_q.last == OP_GET);

    always_comb begin
        do_get = get_req && !is_empty;
        do_put = put_valid && (!is_full || do_get);
        drop   = put_valid && !do_put;

        st_d = st_q;
        if (do_put && !do_get)      st_d.last = OP_PUT;
        else if (do_get && !do_put) st_d.last = OP_GET;

        if (drop)           st_d.ovf = 1'b1;
        else if (ovf_clear) st_d.ovf = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{last: OP_GET, ovf: 1'b0};
        else        st_q <= st_d;
    end

    assign empty    = is_empty;
    assign full     = is_full;
    assign overflow = st_q.ovf;
endmodule

// File: rtl/fifo_lastop_ring.sv
module fifo_lastop_ring #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             put_valid,
    input  logic [WIDTH-1:0] put_data,
    input  logic             get_req,
    output logic [WIDTH-1:0] get_data,
    input  logic             ovf_clear,
    output logic             empty,
    output logic             full,
    output logic             overflow
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int N_PTR = 2;
    localparam int P_PUT = 0;
    localparam int P_GET = 1;

    logic          adv [N_PTR];
    logic [AW-1:0] idx [N_PTR];
    logic          do_put, do_get;

    assign adv[P_PUT] = do_put;
    assign adv[P_GET] = do_get;

    for (genvar gi = 0; gi < N_PTR; gi++) begin : g_ptr
        lor_ptr #(.DEPTH(DEPTH)) u_ptr (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (adv[gi]),
            .idx   (idx[gi])
        );
    end

    lor_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .put_valid (put_valid),
        .get_req   (get_req),
        .ovf_clear (ovf_clear),
        .idx_equal (idx[P_PUT] == idx[P_GET]),
        .do_put    (do_put),
        .do_get    (do_get),
        .empty     (empty),
        .full      (full),
        .overflow  (overflow)
    );

    lor_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .we    (do_put),
        .waddr (idx[P_PUT]),
        .wdata (put_data),
        .raddr (idx[P_GET]),
        .rdata (get_data)
    );
endmodule

// File: rtl/lor_chk.sv
module lor_chk #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             put_valid,
    input logic             get_req,
    input logic             ovf_clear,
    input logic [WIDTH-1:0] get_data,
    input logic             empty,
    input logic             full,
    input logic             overflow
);
    a_r4_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    a_r5_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (full && put_valid && !get_req) |=> (full && overflow && $stable(get_data)));

    a_r6_empty_get_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && get_req && !put_valid) |=> empty);

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clear) |=> overflow);

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clear && !(full && put_valid && !get_req)) |=> !overflow);

    a_r9_full_both: assert property (@(posedge clk) disable iff (!rst_n)
        (full && put_valid && get_req) |=> full);

    a_r10_empty_both: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && put_valid && get_req) |=> !empty);
endmodule

bind fifo_lastop_ring lor_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .put_valid (put_valid),
    .get_req   (get_req),
    .ovf_clear (ovf_clear),
    .get_data  (get_data),
    .empty     (empty),
    .full      (full),
    .overflow  (overflow)
);

// File: tb/sim_fifo_lastop_ring.sv
module sim_fifo_lastop_ring;
    localparam int D = 16;
    localparam int W = 8;
    localparam int NV = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         put_valid = 1'b0;
    logic [W-1:0] put_data = '0;
    logic         get_req = 1'b0;
    logic         ovf_clear = 1'b0;
    logic [W-1:0] get_data;
    logic         empty, full, overflow;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] q[$];
    logic m_ovf = 1'b0;

    // vector: put, get, clr, data[8], exp_empty, exp_full, exp_ovf, check_data, exp_data[8]
    localparam logic [22:0] TBL [NV] = '{
        {1'b1, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 8'h11},
        {1'b1, 1'b0, 1'b0, 8'h22, 1'b0, 1'b0, 1'b0, 1'b1, 8'h11},
        {1'b1, 1'b1, 1'b0, 8'h33, 1'b0, 1'b0, 1'b0, 1'b1, 8'h22},
        {1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h33},
        {1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        {1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
        {1'b1, 1'b1, 1'b0, 8'h44, 1'b0, 1'b0, 1'b0, 1'b1, 8'h44},
        {1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}
    };

    fifo_lastop_ring #(.DEPTH(D), .WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .put_valid(put_valid), .put_data(put_data),
        .get_req(get_req), .get_data(get_data), .ovf_clear(ovf_clear),
        .empty(empty), .full(full), .overflow(overflow)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input bit p, input bit g, input bit c, input logic [W-1:0] dat,
                        input string tag);
        bit ag, ap;
        @(negedge clk);
        put_valid = p; get_req = g; ovf_clear = c; put_data = dat;
        ag = g && (q.size() > 0);
        ap = p && ((q.size() < D) || ag);
        if (p && !ap) m_ovf = 1'b1;
        else if (c)   m_ovf = 1'b0;
        if (ag) void'(q.pop_front());
        if (ap) q.push_back(dat);
        @(posedge clk);
        #1;
        put_valid = 1'b0; get_req = 1'b0; ovf_clear = 1'b0;
        chk(empty == (q.size() == 0), {tag, " empty"}, int'(empty), int'(q.size() == 0));
        chk(full == (q.size() == D), {tag, " full"}, int'(full), int'(q.size() == D));
        chk(overflow == m_ovf, {tag, " overflow"}, int'(overflow), int'(m_ovf));
        if (q.size() > 0)
            chk(get_data == q[0], {tag, " get_data"}, int'(get_data), int'(q[0]));
    endtask

    initial begin
        #(200000 * 20);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        chk(empty == 1'b1, "R1 empty", int'(empty), 1);
        chk(full == 1'b0, "R1 full", int'(full), 0);
        chk(overflow == 1'b0, "R1 overflow", int'(overflow), 0);

        // R2 R6 R8 R10: table walk
        for (int i = 0; i < NV; i++) begin
            logic [22:0] v;
            v = TBL[i];
            step(v[22], v[21], v[20], v[19:12], "R2 table");
            chk(empty == v[11], "R6 table empty", int'(empty), int'(v[11]));
            chk(full == v[10], "R4 table full", int'(full), int'(v[10]));
            chk(overflow == v[9], "R7 table ovf", int'(overflow), int'(v[9]));
            if (v[8]) chk(get_data == v[7:0], "R10 table data", int'(get_data), int'(v[7:0]));
        end

        // R4: fill up to DEPTH
        for (int i = 0; i < D; i++) begin
            step(1'b1, 1'b0, 1'b0, W'(8'hA0 + i), "R4 fill");
            if (i == D - 2) chk(full == 1'b0, "R4 one short", int'(full), 0);
        end
        chk(full == 1'b1, "R4 full at DEPTH", int'(full), 1);

        // R5: dropped put
        step(1'b1, 1'b0, 1'b0, 8'h5A, "R5 drop");
        chk(overflow == 1'b1, "R5 ovf set", int'(overflow), 1);
        // R7: sticky, then clear colliding with drop, then clear alone
        step(1'b0, 1'b0, 1'b0, 8'h00, "R7 sticky");
        step(1'b1, 1'b0, 1'b1, 8'h5B, "R7 clear vs drop");
        chk(overflow == 1'b1, "R7 set wins", int'(overflow), 1);
        step(1'b0, 1'b0, 1'b1, 8'h00, "R7 clear");
        chk(overflow == 1'b0, "R7 cleared", int'(overflow), 0);

        // R9: put and get while full
        step(1'b1, 1'b1, 1'b0, 8'hC1, "R9 full both");
        step(1'b1, 1'b1, 1'b0, 8'hC2, "R9 full both");
        chk(full == 1'b1 && overflow == 1'b0, "R9 stays full", int'({full, overflow}), 2);

        // R2: drain fully, checking order
        while (q.size() > 0) step(1'b0, 1'b1, 1'b0, 8'h00, "R2 drain");
        step(1'b0, 1'b1, 1'b0, 8'h00, "R6 get empty");

        // R3 R8: long mixed stream to wrap many times
        for (int i = 0; i < 120; i++) begin
            bit p, g;
            p = ((i % 3) != 2);
            g = ((i % 4) == 1) || ((i % 5) == 3) || (i > 80);
            step(p, g, 1'b0, W'(i * 7 + 3), "R3 stream");
        end
        while (q.size() > 0) step(1'b0, 1'b1, 1'b0, 8'h00, "R3 drain");

        // R8: both strobes mid-level
        step(1'b1, 1'b0, 1'b0, 8'h61, "R8 prep");
        step(1'b1, 1'b0, 1'b0, 8'h62, "R8 prep");
        step(1'b1, 1'b1, 1'b0, 8'h63, "R8 both");
        chk(empty == 1'b0 && full == 1'b0, "R8 level flags", int'({empty, full}), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule